// File: doc/BRIEF.md
# Bus-interfaced SAR conversion controller

This block is the digital core of an 8-bit successive approximation converter that sits on a microprocessor bus. The host selects the block with an active-low chip select. A write strobe arms the converter and its release starts a conversion. A read strobe fetches the result. An active-low interrupt tells the host that an unread result waits in the output latch.

All three strobes are synchronized into the conversion clock domain before edges are detected. A conversion first pulses a sample strobe for the positive input and then one for the negative input. The comparator bit taken during the negative-sample cycle tells whether the positive input is above the negative one; if it is not, the conversion ends at once with code 0x00. Otherwise the block runs a binary search, one bit per conversion clock, and presents each trial code to the external resistor string and comparator.

The data bus is driven only while chip select and read are both low. At all other times the enable output is low, so the pads can float.

Top module: `sar_bus_ctrl`

## Requirements
- R1: The result is RES_W (8) bits wide. It is found MSB first, one bit per clock: the first trial code is 0x80, each trial sets the current bit on top of the bits already kept, and a bit is kept when cmp_i is 1 (input at or above the trial level). For a difference D = Vp − Vn in LSB with 0 ≤ D ≤ 255, the result is D.
- R2: A falling write with chip select low drives intr_no high and arms the converter. A write strobe with chip select high is ignored.
- R3: A conversion starts on the rising write strobe of an armed converter. With the input driven just before a clock edge, intr_no falls SYNC_STAGES + 3 + RES_W clocks later (13 with the defaults).
- R4: At the end of the search, the final code is copied into the output latch and intr_no goes low.
- R5: intr_no stays low until the result is read or a new write arrives.
- R6: With cs_ni and rd_ni both low, data_oe_o is 1 and data_o carries the latched result, and intr_no is released high. Otherwise data_oe_o is 0.
- R7: samp_pos_o pulses for one clock. samp_neg_o pulses in the very next clock. The two never coincide.
- R8: If cmp_i is 0 during the negative-sample cycle (negative input at or above positive), the result is 0x00. The conversion then ends SYNC_STAGES + 3 clocks after the write rises (5 with the defaults).
- R9: A write strobe during a conversion aborts it. Conversion then restarts from the positive sample on that strobe's release, and only the new result is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| cmp_i | input | 1 | Comparator decision: positive side at or above trial level |
| trial_o | output | RES_W | Trial code to the resistor string |
| samp_pos_o | output | 1 | Sample strobe for the positive input |
| samp_neg_o | output | 1 | Sample strobe for the negative input |
| intr_no | output | 1 | Result-ready interrupt, active low |
| data_o | output | RES_W | Latched result for the data bus |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The hardest situation to reach is a write that lands in the middle of a running search. The abort must discard the half-built code and restart sampling with no stale result reaching the latch. The bench reaches it by starting one conversion and then, a few clocks into the search, issuing a second write with different input voltages. It then checks that the final code matches only the second pair.

A comparator model in the bench captures the inputs on the sample strobes and answers each trial code. This lets randomly chosen voltage pairs, including the clamp case, be checked against a simple subtraction. A second directed scenario also has to be built on purpose: a write pulsed with chip select high while a result is pending, which must leave the interrupt low.

// File: rtl/sar_bus_pkg.sv
package sar_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SAMP_P,
    ST_SAMP_N,
    ST_SEARCH
  } conv_state_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '1;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '1;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_bus_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             samp_pos_o,
  output logic             samp_neg_o,
  output logic             armed_o,
  output logic             done_o,
  output logic [RES_W-1:0] code_o
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);

  conv_state_e      state_q;
  logic [RES_W-1:0] code_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] bit_mask;
  logic [RES_W-1:0] keep_code;
  logic             in_search;

  assign in_search  = (state_q == ST_SEARCH);
  assign bit_mask   = RES_W'(1) << idx_q;
  assign trial_o    = in_search ? (code_q | bit_mask) : '0;
  assign keep_code  = cmp_i ? trial_o : code_q;
  assign samp_pos_o = (state_q == ST_SAMP_P);
  assign samp_neg_o = (state_q == ST_SAMP_N);
  assign armed_o    = (state_q == ST_ARMED);
  assign code_o     = in_search ? keep_code : '0;

  // clamp path ends at the negative-sample cycle
  assign done_o = !arm_i &&
                  ((in_search && idx_q == '0) || (samp_neg_o && !cmp_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      idx_q   <= '0;
    end else if (arm_i) begin
      state_q <= ST_ARMED;
      code_q  <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_ARMED:  if (start_i) state_q <= ST_SAMP_P;
        ST_SAMP_P: state_q <= ST_SAMP_N;
        ST_SAMP_N: begin
          code_q <= '0;
          idx_q  <= IDX_TOP;
          state_q <= cmp_i ? ST_SEARCH : ST_IDLE;
        end
        ST_SEARCH: begin
          code_q <= keep_code;
          if (idx_q == '0) state_q <= ST_IDLE;
          else             idx_q   <= idx_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_latch.sv
module bus_latch #(
  parameter int RES_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             rd_clr_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] code_i,
  output logic             intr_no,
  output logic [RES_W-1:0] result_o
);
  logic             intr_q;
  logic [RES_W-1:0] result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intr_q   <= 1'b1;
      result_q <= '0;
    end else if (arm_i) begin
      intr_q <= 1'b1;
    end else if (done_i) begin
      intr_q   <= 1'b0;
      result_q <= code_i;
    end else if (rd_clr_i) begin
      intr_q <= 1'b1;
    end
  end

  assign intr_no  = intr_q;
  assign result_o = result_q;
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
  parameter int RES_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             wr_ni,
  input  logic             rd_ni,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             samp_pos_o,
  output logic             samp_neg_o,
  output logic             intr_no,
  output logic [RES_W-1:0] data_o,
  output logic             data_oe_o
);
  logic [2:0]       strb_s;
  logic             cs_s, wr_s, rd_s;
  logic             wr_prev_q, rd_act_prev_q;
  logic             rd_act, wr_fall, wr_rise, rd_clr;
  logic             engine_armed, conv_done;
  logic [RES_W-1:0] conv_code;

  strobe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, wr_ni, rd_ni}),
    .q_o   (strb_s)
  );

  assign {cs_s, wr_s, rd_s} = strb_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_prev_q     <= 1'b1;
      rd_act_prev_q <= 1'b0;
    end else begin
      wr_prev_q     <= wr_s;
      rd_act_prev_q <= rd_act;
    end
  end

  assign rd_act  = !cs_s && !rd_s;
  assign wr_fall = !cs_s && !wr_s && wr_prev_q;
  assign wr_rise = wr_s && !wr_prev_q;
  assign rd_clr  = rd_act && !rd_act_prev_q;

  sar_engine #(.RES_W(RES_W)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (wr_fall),
    .start_i   (wr_rise),
    .cmp_i     (cmp_i),
    .trial_o   (trial_o),
    .samp_pos_o(samp_pos_o),
    .samp_neg_o(samp_neg_o),
    .armed_o   (engine_armed),
    .done_o    (conv_done),
    .code_o    (conv_code)
  );

  bus_latch #(.RES_W(RES_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (wr_fall),
    .rd_clr_i(rd_clr),
    .done_i  (conv_done),
    .code_i  (conv_code),
    .intr_no (intr_no),
    .result_o(data_o)
  );

  // drive enable follows the pins directly so the bus turns around at once
  assign data_oe_o = !cs_ni && !rd_ni;
endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
  parameter int RES_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_fall,
  input logic             wr_rise,
  input logic             rd_clr,
  input logic             armed,
  input logic             done,
  input logic             cmp_i,
  input logic [RES_W-1:0] code,
  input logic [RES_W-1:0] trial_o,
  input logic             samp_pos_o,
  input logic             samp_neg_o,
  input logic             intr_no,
  input logic [RES_W-1:0] data_o
);
  assert_arm_clears_intr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fall |=> intr_no);

  assert_start_samples_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rise && armed && !wr_fall) |=> samp_pos_o);

  assert_done_latches_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (!intr_no && data_o == $past(code)));

  assert_intr_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!intr_no && !rd_clr && !wr_fall) |=> !intr_no);

  assert_read_releases_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && !done && !wr_fall) |=> intr_no);

  assert_neg_after_pos_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_neg_o |-> $past(samp_pos_o));

  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({samp_pos_o, samp_neg_o}));

  assert_clamp_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_neg_o && !cmp_i && done) |=> (data_o == '0));

  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fall |=> (!samp_pos_o && !samp_neg_o && trial_o == '0));
endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_fall   (wr_fall),
  .wr_rise   (wr_rise),
  .rd_clr    (rd_clr),
  .armed     (engine_armed),
  .done      (conv_done),
  .cmp_i     (cmp_i),
  .code      (conv_code),
  .trial_o   (trial_o),
  .samp_pos_o(samp_pos_o),
  .samp_neg_o(samp_neg_o),
  .intr_no   (intr_no),
  .data_o    (data_o)
);

// File: tb/sar_bus_ctrl_tb.sv
`timescale 1ns/1ps
module sar_bus_ctrl_tb;
  localparam int RES_W = 8;
  localparam int SYNC  = 2;
  localparam int LAT_FULL  = SYNC + 3 + RES_W;
  localparam int LAT_CLAMP = SYNC + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic cmp;
  logic [RES_W-1:0] trial, data;
  logic samp_p, samp_n, intr_n, data_oe;

  int vin_p = 0, vin_n = 0;
  int vp_cap = 0, vn_cap = 0;
  int checks = 0, errors = 0;
  int order_bad = 0, msb_bad = 0;
  int cyc_cnt = 0;
  bit done_flag = 0;
  logic prev_p = 0, prev_n = 0;

  always #5 clk = ~clk;

  sar_bus_ctrl #(.RES_W(RES_W), .SYNC_STAGES(SYNC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .rd_ni(rd_n),
    .cmp_i(cmp), .trial_o(trial), .samp_pos_o(samp_p), .samp_neg_o(samp_n),
    .intr_no(intr_n), .data_o(data), .data_oe_o(data_oe)
  );

  // analog front-end model
  always_ff @(posedge clk) begin
    if (samp_p) vp_cap <= vin_p;
    if (samp_n) vn_cap <= vin_n;
  end
  assign cmp = samp_n ? (vp_cap > vin_n) : ((vp_cap - vn_cap) >= int'(trial));

  // sampling order and first-trial monitor (R7, R1)
  always @(negedge clk) begin
    if (rst_n) begin
      if (samp_n && !prev_p) order_bad++;
      if (samp_p && samp_n) order_bad++;
      if (prev_n && trial != 0 && trial != 8'h80) msb_bad++;
    end
    prev_p = samp_p;
    prev_n = samp_n;
  end

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc_cnt);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int p, input int n);
    return (p > n) ? (p - n) : 0;
  endfunction

  task automatic start_conv(input int p, input int n, input bit chk_arm);
    vin_p = p; vin_n = n;
    @(negedge clk); cs_n = 0; wr_n = 0;
    repeat (4) @(negedge clk);
    if (chk_arm) check(intr_n == 1'b1, "R2 write clears intr", intr_n, 1);
    wr_n = 1; cs_n = 1;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (intr_n && cyc < 200) begin
      @(negedge clk); cyc++;
    end
  endtask

  task automatic read_res(output logic [RES_W-1:0] d, output logic oe);
    @(negedge clk); cs_n = 0; rd_n = 0;
    #1; d = data; oe = data_oe;
    repeat (4) @(negedge clk);
    cs_n = 1; rd_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic convert_and_check(input int p, input int n, input string req);
    int cyc;
    logic [RES_W-1:0] d;
    logic oe;
    start_conv(p, n, 1'b0);
    wait_done(cyc);
    check(intr_n == 1'b0, {req, " R4 intr low at end"}, intr_n, 0);
    read_res(d, oe);
    check(oe && int'(d) == expect_code(p, n), {req, " R1 result"}, int'(d), expect_code(p, n));
  endtask

  initial begin
    int cyc;
    logic [RES_W-1:0] d;
    logic oe;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk);
    check(intr_n == 1'b1, "reset intr", intr_n, 1);
    check(data_oe == 1'b0, "reset R6 oe", data_oe, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // directed: latency, hold, ignored write, read
    start_conv(200, 50, 1'b1);
    wait_done(cyc);
    check(cyc == LAT_FULL, "R3 conversion latency", cyc, LAT_FULL);
    check(intr_n == 1'b0, "R4 intr low", intr_n, 0);
    repeat (20) @(negedge clk);
    check(intr_n == 1'b0, "R5 intr held", intr_n, 0);
    @(negedge clk); wr_n = 0;
    repeat (4) @(negedge clk); wr_n = 1;
    repeat (8) @(negedge clk);
    check(intr_n == 1'b0, "R2 write without cs ignored", intr_n, 0);
    @(negedge clk); rd_n = 0; #1;
    check(data_oe == 1'b0, "R6 read without cs no drive", data_oe, 0);
    repeat (6) @(negedge clk);
    check(intr_n == 1'b0, "R6 read without cs keeps intr", intr_n, 0);
    rd_n = 1;
    read_res(d, oe);
    check(oe == 1'b1, "R6 read drives bus", oe, 1);
    check(d == 8'd150, "R1 R6 read data", int'(d), 150);
    check(intr_n == 1'b1, "R6 read releases intr", intr_n, 1);
    #1; check(data_oe == 1'b0, "R6 idle high-Z", data_oe, 0);

    // new write while result pending clears intr (R2)
    start_conv(30, 10, 1'b0);
    wait_done(cyc);
    start_conv(40, 10, 1'b1);
    wait_done(cyc);
    read_res(d, oe);
    check(d == 8'd30, "R2 rearm result", int'(d), 30);

    // corners
    convert_and_check(255, 0, "corner full");
    convert_and_check(1, 0, "corner one");
    convert_and_check(128, 127, "corner mid");
    convert_and_check(127, 0, "corner below msb");

    // clamp
    start_conv(0, 0, 1'b0);
    wait_done(cyc);
    check(cyc == LAT_CLAMP, "R8 clamp latency", cyc, LAT_CLAMP);
    read_res(d, oe);
    check(d == 8'd0, "R8 equal inputs", int'(d), 0);
    convert_and_check(10, 200, "R8 negative above");

    // abort mid-search (R9)
    start_conv(100, 20, 1'b0);
    repeat (7) @(negedge clk);
    check(intr_n == 1'b1, "R9 still converting", intr_n, 1);
    start_conv(90, 30, 1'b0);
    wait_done(cyc);
    check(cyc == LAT_FULL, "R9 restart latency", cyc, LAT_FULL);
    read_res(d, oe);
    check(d == 8'd60, "R9 abort result", int'(d), 60);

    // random
    for (int i = 0; i < 40; i++) begin
      int p, n;
      p = int'($urandom_range(255, 0));
      n = (i % 5 == 0) ? int'($urandom_range(255, 0)) : int'($urandom_range(p, 0));
      convert_and_check(p, n, "random");
    end

    check(order_bad == 0, "R7 sample order", order_bad, 0);
    check(msb_bad == 0, "R1 first trial is MSB", msb_bad, 0);
    summary();
  end
endmodule